// File: doc/BRIEF.md
# Audio CPU Address Decoder with Boot ROM Overlay

This block sits between a small audio processor and the three things its 16-bit address space can reach. It steers every processor request to one target and returns read data with one cycle of latency. The targets are a bank of peripheral registers in page zero, a 64-byte boot ROM that can shadow the top of memory, and a 64 KB RAM outside the block.

The register bank is a window of sixteen indices starting at 0x00F0. Indices 8 and 9 (addresses 0x00F8 and 0x00F9) are not registers: those two addresses fall through to RAM. For a register access the block passes the index, the direction and a peek flag to the peripheral side. A peek read lets a debugger or the processor's own control logic look at a register without triggering its read side effects.

The boot ROM answers reads at the top 64 addresses only while the boot-map input is high. That input is driven straight from bit 7 of peripheral register 1, and sampling it creates no register strobe. Writes to those addresses always land in RAM.

Top module: `mmap_decoder`

## Requirements
- R1: A request with address 0x00F0..0x00F7 or 0x00FA..0x00FF raises `reg_sel` in the same cycle. `reg_idx` equals the address minus 0x00F0, and `reg_we` follows `cpu_we`. A read returns `reg_rdata`.
- R2: Addresses 0x00F8 and 0x00F9 never raise `reg_sel`. Reads and writes there go to RAM.
- R3: A read at 0xFFC0..0xFFFF with `boot_map` high returns byte (address − 0xFFC0) of the ROM image. Byte k occupies bits [8k+7:8k] of `ROM_IMG`. Such a read raises neither `mem_en` nor `reg_sel`.
- R4: A read at 0xFFC0..0xFFFF with `boot_map` low returns RAM contents.
- R5: A write at 0xFFC0..0xFFFF raises `mem_en` and `mem_we` whatever the level of `boot_map`. The data is readable afterwards once the overlay is off.
- R6: A register access never raises `mem_en`, so a register write leaves RAM untouched.
- R7: `reg_peek` is high only for a register read with `cpu_peek` set. A peek read does not consume register data, so a later normal read returns the same value.
- R8: `cpu_rvalid` is high in exactly the cycle after each read request, and never after a write. `cpu_rdata` is valid in that cycle for every target.
- R9: After reset `cpu_rvalid` is low. With `cpu_req` low, no target strobe (`reg_sel`, `mem_en`) is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_peek | input | 1 | Side-effect-free read qualifier |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after the request |
| cpu_rvalid | output | 1 | Read data valid |
| boot_map | input | 1 | ROM overlay enable (control register 1, bit 7) |
| reg_sel | output | 1 | Peripheral register access strobe |
| reg_we | output | 1 | Peripheral register write |
| reg_peek | output | 1 | Peripheral read must not cause side effects |
| reg_idx | output | 4 | Peripheral register index |
| reg_wdata | output | 8 | Peripheral write data |
| reg_rdata | input | 8 | Peripheral read data, one cycle after `reg_sel` |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write |
| mem_addr | output | 16 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_en` |

## Verification
The bench keeps the default map: 16-bit addresses, sixteen registers at 0x00F0 with the two-index hole, and a 64-byte ROM. It overrides `ROM_IMG` with a computed non-zero pattern. With the all-zero default image, a ROM hit could not be told apart from untouched RAM. The bench also models the peripheral so that a normal read clears a register. Peek and non-peek reads then give different data, and a peek that does consume state shows up in what `cpu_rdata` returns.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_ROM  = 2'd2,
    TGT_RAM  = 2'd3
  } tgt_e;
endpackage

// File: rtl/mmap_route.sv
// Combinational address decode: picks one target per request.
module mmap_route
  import mmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REG_BASE  = 'hF0,
  parameter int REG_COUNT = 16,
  parameter int HOLE_LO   = 8,
  parameter int HOLE_LEN  = 2,
  parameter int ROM_BYTES = 64
) (
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic                         boot_map,
  output tgt_e                         tgt,
  output logic [$clog2(REG_COUNT)-1:0] idx,
  output logic [$clog2(ROM_BYTES)-1:0] rom_idx
);
  localparam int IDX_W  = $clog2(REG_COUNT);
  localparam int ROM_AW = $clog2(ROM_BYTES);
  localparam logic [ADDR_W-1:0] REG_LO = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-IDX_W-1:0] WIN_TAG = REG_LO[ADDR_W-1:IDX_W];
  localparam logic [ADDR_W-ROM_AW-1:0] TOP_TAG = '1;

  logic in_win, in_hole, in_top;

  always_comb begin
    idx     = cpu_addr[IDX_W-1:0];
    rom_idx = cpu_addr[ROM_AW-1:0];
    in_win  = cpu_addr[ADDR_W-1:IDX_W] == WIN_TAG;
    in_hole = (int'(idx) >= HOLE_LO) && (int'(idx) < HOLE_LO + HOLE_LEN);
    in_top  = cpu_addr[ADDR_W-1:ROM_AW] == TOP_TAG;
    tgt     = TGT_NONE;
    if (cpu_req) begin
      if (in_win && !in_hole)              tgt = TGT_REG;
      else if (!cpu_we && boot_map && in_top) tgt = TGT_ROM;
      else                                 tgt = TGT_RAM;
    end
  end
endmodule

// File: rtl/mmap_bootrom.sv
// Boot ROM with registered read port, contents from a packed parameter.
module mmap_bootrom #(
  parameter int DATA_W    = 8,
  parameter int ROM_BYTES = 64,
  parameter logic [ROM_BYTES*DATA_W-1:0] ROM_IMG = '0
) (
  input  logic                         clk,
  input  logic                         rd_en,
  input  logic [$clog2(ROM_BYTES)-1:0] rd_idx,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] rom_arr [ROM_BYTES];

  for (genvar i = 0; i < ROM_BYTES; i++) begin : g_word
    assign rom_arr[i] = ROM_IMG[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= rom_arr[rd_idx];
  end
endmodule

// File: rtl/mmap_return.sv
// Read return stage: remembers the target of a read and selects its data.
module mmap_return
  import mmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] reg_data,
  input  logic [DATA_W-1:0] rom_data,
  input  logic [DATA_W-1:0] ram_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  tgt_e tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      tgt_q  <= TGT_NONE;
    end else begin
      rvalid <= launch;
      tgt_q  <= launch ? tgt : TGT_NONE;
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_REG: rdata = reg_data;
      TGT_ROM: rdata = rom_data;
      TGT_RAM: rdata = ram_data;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_BASE  = 'hF0,
  parameter int REG_COUNT = 16,
  parameter int HOLE_LO   = 8,
  parameter int HOLE_LEN  = 2,
  parameter int ROM_BYTES = 64,
  parameter logic [ROM_BYTES*DATA_W-1:0] ROM_IMG = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic                         cpu_peek,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         cpu_rvalid,
  input  logic                         boot_map,
  output logic                         reg_sel,
  output logic                         reg_we,
  output logic                         reg_peek,
  output logic [$clog2(REG_COUNT)-1:0] reg_idx,
  output logic [DATA_W-1:0]            reg_wdata,
  input  logic [DATA_W-1:0]            reg_rdata,
  output logic                         mem_en,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata
);
  localparam int ROM_AW = $clog2(ROM_BYTES);

  tgt_e              tgt;
  logic [ROM_AW-1:0] rom_idx;
  logic [DATA_W-1:0] rom_q;
  logic              launch;

  mmap_route #(
    .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .REG_COUNT(REG_COUNT),
    .HOLE_LO(HOLE_LO), .HOLE_LEN(HOLE_LEN), .ROM_BYTES(ROM_BYTES)
  ) u_route (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .boot_map(boot_map), .tgt(tgt), .idx(reg_idx), .rom_idx(rom_idx)
  );

  always_comb begin
    reg_sel   = tgt == TGT_REG;
    reg_we    = reg_sel && cpu_we;
    reg_peek  = reg_sel && cpu_peek && !cpu_we;
    reg_wdata = cpu_wdata;
    mem_en    = tgt == TGT_RAM;
    mem_we    = mem_en && cpu_we;
    mem_addr  = cpu_addr;
    mem_wdata = cpu_wdata;
    launch    = cpu_req && !cpu_we;
  end

  mmap_bootrom #(
    .DATA_W(DATA_W), .ROM_BYTES(ROM_BYTES), .ROM_IMG(ROM_IMG)
  ) u_rom (
    .clk(clk), .rd_en(tgt == TGT_ROM), .rd_idx(rom_idx), .rd_data(rom_q)
  );

  mmap_return #(.DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst(rst), .launch(launch), .tgt(tgt),
    .reg_data(reg_rdata), .rom_data(rom_q), .ram_data(mem_rdata),
    .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk #(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              reg_sel,
  input logic              reg_we,
  input logic              reg_peek,
  input logic              mem_en,
  input logic              mem_we,
  input logic              cpu_rvalid
);
  localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'((1 << ADDR_W) - ROM_BYTES);

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_sel, mem_en}));

  // R5
  top_write_ram_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && cpu_addr >= ROM_LO) |-> (mem_en && mem_we));

  // R7
  peek_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    reg_peek |-> (reg_sel && !reg_we && !cpu_we));

  // R8
  read_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we) |=> cpu_rvalid);

  // R8
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_req && !cpu_we) |=> !cpu_rvalid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |-> (!reg_sel && !mem_en));
endmodule

bind mmap_decoder mmap_decoder_chk #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .reg_sel(reg_sel), .reg_we(reg_we), .reg_peek(reg_peek),
  .mem_en(mem_en), .mem_we(mem_we), .cpu_rvalid(cpu_rvalid)
);

// File: tb/test_mmap_decoder.sv
module test_mmap_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64;

  function automatic logic [NB*8-1:0] make_img();
    logic [NB*8-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'hC5 ^ 8'(i * 3);
    return v;
  endfunction
  localparam logic [NB*8-1:0] IMG = make_img();

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0, cpu_peek = 0, boot_map = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic cpu_rvalid, reg_sel, reg_we, reg_peek, mem_en, mem_we;
  logic [3:0]  reg_idx;
  logic [7:0]  reg_wdata, reg_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  mmap_decoder #(.ROM_IMG(IMG)) i_mmap_decoder (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_peek(cpu_peek),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .boot_map(boot_map), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_peek(reg_peek), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ram_m [int];
  logic [7:0] regs_m [16];
  logic [7:0] exp_ram [int];
  logic [7:0] exp_reg [16];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  // Peripheral model: a normal read consumes (clears) the register.
  always @(posedge clk) begin
    if (reg_sel) begin
      if (reg_we) regs_m[reg_idx] <= reg_wdata;
      else begin
        reg_rdata <= regs_m[reg_idx];
        if (!reg_peek) regs_m[reg_idx] <= 8'h00;
      end
    end
  end

  // RAM model, synchronous read.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram_m[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= ram_m.exists(int'(mem_addr)) ? ram_m[int'(mem_addr)] : 8'h00;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every returned read.
  always @(negedge clk) begin
    if (!rst && cpu_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected rvalid", 16'(cpu_rvalid), 16'h0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(cpu_rdata === e, t, 16'(cpu_rdata), 16'(e));
      end
    end
  end

  function automatic bit is_reg(input logic [15:0] a);
    return a[15:4] == 12'h00F && a[3:0] != 4'h8 && a[3:0] != 4'h9;
  endfunction

  task automatic idle();
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; cpu_peek = 0;
    #1 chk(!reg_sel && !mem_en, "R9 idle strobes", {14'h0, reg_sel, mem_en}, 16'h0);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic bm, input string t);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_peek = 0; cpu_addr = a; cpu_wdata = d; boot_map = bm;
    #1;
    if (is_reg(a)) begin
      exp_reg[a[3:0]] = d;
      chk(reg_sel && reg_we && reg_idx == a[3:0] && !mem_en, t,
          {reg_sel, reg_we, mem_en, 9'h0, reg_idx}, {3'b110, 9'h0, a[3:0]});
    end else begin
      exp_ram[int'(a)] = d;
      chk(mem_en && mem_we && !reg_sel && mem_addr == a, t, mem_addr, a);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic pk, input logic bm, input string t);
    logic [7:0] e;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_peek = pk; cpu_addr = a; boot_map = bm;
    #1;
    if (is_reg(a)) begin
      e = exp_reg[a[3:0]];
      if (!pk) exp_reg[a[3:0]] = 8'h00;
      chk(reg_sel && !mem_en && reg_idx == a[3:0] && reg_peek == pk, t,
          {reg_sel, mem_en, reg_peek, 9'h0, reg_idx}, {2'b10, pk, 9'h0, a[3:0]});
    end else if (bm && a >= 16'hFFC0) begin
      e = IMG[int'(a - 16'hFFC0)*8 +: 8];
      chk(!mem_en && !reg_sel, {t, " no strobe"}, {14'h0, reg_sel, mem_en}, 16'h0);
    end else begin
      e = exp_ram.exists(int'(a)) ? exp_ram[int'(a)] : 8'h00;
      chk(mem_en && !mem_we && !reg_sel, t, {14'h0, mem_en, reg_sel}, 16'h2);
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin regs_m[i] = 8'h00; exp_reg[i] = 8'h00; end
    reg_rdata = 0; mem_rdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_rvalid == 0, "R9 rvalid in reset", 16'(cpu_rvalid), 16'h0);
    rst = 0;
    idle();
    chk(cpu_rvalid == 0, "R9 rvalid after reset", 16'(cpu_rvalid), 16'h0);

    // R1: every register index of the window, both halves
    for (int i = 0; i < 16; i++)
      if (i != 8 && i != 9) wr(16'h00F0 + 16'(i), 8'h30 + 8'(i), 0, "R1 reg write");
    rd(16'h00F0, 0, 0, "R1 reg read F0");
    rd(16'h00F7, 0, 0, "R1 reg read F7");
    rd(16'h00FA, 0, 0, "R1 reg read FA");
    rd(16'h00FF, 0, 0, "R1 reg read FF");
    idle();
    // R2: hole falls to RAM
    wr(16'h00F8, 8'h88, 0, "R2 hole write F8");
    wr(16'h00F9, 8'h99, 0, "R2 hole write F9");
    rd(16'h00F8, 0, 0, "R2 hole read F8");
    rd(16'h00F9, 0, 0, "R2 hole read F9");
    // R6: register write leaves RAM at same address alone
    chk(!ram_m.exists(16'h00F3), "R6 RAM untouched", 16'h1, 16'h0);
    // R7: peek does not consume
    wr(16'h00F3, 8'h5A, 0, "R7 setup");
    rd(16'h00F3, 1, 0, "R7 peek read");
    rd(16'h00F3, 1, 0, "R7 second peek");
    rd(16'h00F3, 0, 0, "R7 normal read after peek");
    rd(16'h00F3, 0, 0, "R7 consumed");
    // R5: writes to top area go to RAM even with overlay on
    wr(16'hFFC0, 8'h11, 1, "R5 top write overlay on");
    wr(16'hFFFF, 8'h22, 1, "R5 top write overlay on");
    wr(16'hFFD5, 8'h33, 0, "R5 top write overlay off");
    // R3: overlay reads
    rd(16'hFFC0, 0, 1, "R3 rom first byte");
    rd(16'hFFD5, 0, 1, "R3 rom mid byte");
    rd(16'hFFFF, 0, 1, "R3 rom last byte");
    rd(16'hFFBF, 0, 1, "R3 below rom is RAM");
    // R4: overlay off
    rd(16'hFFC0, 0, 0, "R4 top RAM");
    rd(16'hFFFF, 0, 0, "R4 top RAM");
    rd(16'hFFD5, 0, 0, "R4 top RAM");
    // R8: mixed back-to-back, writes produce no response
    wr(16'h1234, 8'hA7, 0, "R8 plain write");
    rd(16'h1234, 0, 0, "R8 read after write");
    wr(16'h00F1, 8'h80, 0, "R8 write between reads");
    rd(16'h00F1, 1, 1, "R8 peek ctl");
    rd(16'hFFC1, 0, 1, "R8 rom after reg");
    idle();
    idle();
    chk(exp_q.size() == 0, "R8 all reads returned", 16'(exp_q.size()), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule